// File: doc/BRIEF.md
# General-Purpose I/O Bank with Interrupt Sensing

This block is one bank of up to 32 general-purpose lines behind a simple word-wide register bus. The bus has a byte address, a write strobe, write data and read data. Reads are combinational and writes take effect at the next clock edge. Each line is set up in one of three ways:

- a plain input, whose pad value can be read;
- a driven output, whose pad enable and pad value come from the bank;
- an interrupt input, whose pad activity is latched or tracked as status.

The bank merges all unmasked status into a single interrupt request.

Pad inputs arrive already synchronized. The bank keeps these registers:

- line mode;
- direction;
- output data;
- polarity;
- trigger type (edge or level);
- a dual-edge select;
- the interrupt enable mask.

There are two ways to change the mask. A write to the mask offset can only clear bits. A write to a separate enable offset can only set bits. Because of this, two agents can each enable their own lines without a read-modify-write race.

An internal sense unit receives the mode, polarity, trigger and dual-edge settings, together with one-cycle clear pulses. It then produces the per-line status vector. Input filtering is not implemented, and its offset reads as zero.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads 0. `pad_oe` is all zero and `irq` is 0.
- R2: A pad is driven (`pad_oe` bit = 1) exactly when its mode bit (offset 0x00) is 0 and its direction bit (offset 0x04, 1 = output) is 1. `pad_out` carries the output-data register (offset 0x08). Both outputs change only in the cycle after a bus write.
- R3: A read of offset 0x0C returns the output-data bit for driven lines and the `pad_in` bit for all other lines.
- R4: A write to offset 0x18 clears each mask bit written as 0 and leaves bits written as 1 unchanged. A write of 1 to a bit of offset 0x1C sets that mask bit. Offset 0x18 reads back the mask.
- R5: Offset 0x10 reads the status vector whatever the mask holds. `irq` is 1 exactly when some line has both its status bit and its mask bit at 1.
- R6: For a line with mode bit 1 and edge bit (offset 0x24) 1, the status bit is set one clock edge after the pad changes. With polarity bit (offset 0x20) 0 a rising change sets it; with polarity bit 1 a falling change sets it. Once set, the bit holds until a 1 is written to that line's bit at offset 0x14. Writing 0 there has no effect.
- R7: For an edge-mode line whose dual-edge bit (offset 0x4C) is 1, both rising and falling changes set status, regardless of polarity.
- R8: For a line with mode bit 1 and edge bit 0, the status bit equals `pad_in` XOR polarity as sampled at the previous clock edge. Writes to offset 0x14 do not affect it.
- R9: A line whose mode bit is 0 never shows a status bit of 1.
- R10: Reads of offsets 0x14, 0x1C and 0x28 and of unmapped offsets return 0. Writes to 0x28 or to unmapped offsets change no register.
- R11: If a qualifying edge arrives in the same cycle as a clear write for that line, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 7 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NLINES | Synchronized pad input values |
| pad_oe | output | NLINES | Pad output enables |
| pad_out | output | NLINES | Pad output values |
| irq | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle:

- a write to the mask offset never sets a mask bit;
- a line in general I/O mode never carries status;
- the pad outputs move only after a bus write;
- the write-only and unmapped offsets always read zero;
- the state right after reset is quiet.

Some behaviour can only be shown by the bench's scenarios. These are the trigger behaviour of each line under every combination of polarity, trigger type and dual-edge select, the race between a clear and a new edge, and the readback of the pad for driven lines. For these, the bench sweeps all 32 lines through all eight trigger settings. It also toggles the other lines in opposite phase.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned MAX_LINES = 32;
    localparam int unsigned ADDR_W    = 7;

    localparam logic [ADDR_W-1:0] OFF_MODE  = 7'h00;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 7'h04;
    localparam logic [ADDR_W-1:0] OFF_DOUT  = 7'h08;
    localparam logic [ADDR_W-1:0] OFF_DIN   = 7'h0C;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 7'h10;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 7'h14;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 7'h18;
    localparam logic [ADDR_W-1:0] OFF_MSET  = 7'h1C;
    localparam logic [ADDR_W-1:0] OFF_POL   = 7'h20;
    localparam logic [ADDR_W-1:0] OFF_EDGE  = 7'h24;
    localparam logic [ADDR_W-1:0] OFF_FILT  = 7'h28;
    localparam logic [ADDR_W-1:0] OFF_DUAL  = 7'h4C;

    typedef logic [MAX_LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t mode;   // 1: interrupt input, 0: general I/O
        line_vec_t dir;    // 1: output, 0: input
        line_vec_t dout;   // output data
        line_vec_t mask;   // 1: interrupt enabled
        line_vec_t pol;    // 1: active low / falling
        line_vec_t edg;    // 1: edge, 0: level
        line_vec_t dual;   // 1: both edges
    } cfg_t;

    typedef struct packed {
        line_vec_t prev;   // pad sample from the previous edge
        line_vec_t status; // per-line interrupt status
    } sense_t;

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NLINES   = 32,
    parameter bit          HAS_DUAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output cfg_t              cfg_q,
    output line_vec_t         clr_pulse
);

    localparam line_vec_t LINE_MASK = line_vec_t'((64'd1 << NLINES) - 64'd1);

    cfg_t      cfg_d;
    line_vec_t wd;

    assign wd = line_vec_t'(bus_wdata) & LINE_MASK;

    always_comb begin
        cfg_d     = cfg_q;
        clr_pulse = '0;
        if (bus_we) begin
            case (bus_addr)
                OFF_MODE: cfg_d.mode = wd;
                OFF_DIR:  cfg_d.dir  = wd;
                OFF_DOUT: cfg_d.dout = wd;
                OFF_CLR:  clr_pulse  = wd;
                OFF_MASK: cfg_d.mask = cfg_q.mask & wd;
                OFF_MSET: cfg_d.mask = cfg_q.mask | wd;
                OFF_POL:  cfg_d.pol  = wd;
                OFF_EDGE: cfg_d.edg  = wd;
                OFF_DUAL: if (HAS_DUAL) cfg_d.dual = wd;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense
    import gpio_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t pad,
    input  line_vec_t mode,
    input  line_vec_t pol,
    input  line_vec_t edg,
    input  line_vec_t dual,
    input  line_vec_t clr,
    output line_vec_t status_q
);

    sense_t    st_d;
    sense_t    st_q;
    line_vec_t nxt_status;

    for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
        logic rise_w;
        logic fall_w;
        logic hit_w;
        logic act_w;
        assign rise_w = pad[i] & ~st_q.prev[i];
        assign fall_w = ~pad[i] & st_q.prev[i];
        assign hit_w  = dual[i] ? (rise_w | fall_w) : (pol[i] ? fall_w : rise_w);
        assign act_w  = pad[i] ^ pol[i];
        assign nxt_status[i] = !mode[i] ? 1'b0 :
                               edg[i]   ? (hit_w | (st_q.status[i] & ~clr[i])) :
                                          act_w;
    end

    always_comb begin
        st_d.prev   = pad;
        st_d.status = nxt_status;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign status_q = st_q.status;

endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
    import gpio_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  cfg_t              cfg,
    input  line_vec_t         pad,
    input  line_vec_t         status,
    output logic [31:0]       rdata
);

    line_vec_t drv;
    line_vec_t din;

    assign drv = ~cfg.mode & cfg.dir;
    assign din = (drv & cfg.dout) | (~drv & pad);

    always_comb begin
        case (bus_addr)
            OFF_MODE: rdata = cfg.mode;
            OFF_DIR:  rdata = cfg.dir;
            OFF_DOUT: rdata = cfg.dout;
            OFF_DIN:  rdata = din;
            OFF_STAT: rdata = status;
            OFF_MASK: rdata = cfg.mask;
            OFF_POL:  rdata = cfg.pol;
            OFF_EDGE: rdata = cfg.edg;
            OFF_DUAL: rdata = cfg.dual;
            OFF_CLR, OFF_MSET, OFF_FILT: rdata = '0;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NLINES   = 32,
    parameter bit          HAS_DUAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] pad_out,
    output logic              irq
);

    cfg_t      cfg_q;
    line_vec_t clr_pulse;
    line_vec_t status_q;
    line_vec_t pad_ext;
    line_vec_t oe_full;

    always_comb begin
        pad_ext             = '0;
        pad_ext[NLINES-1:0] = pad_in;
    end

    gpio_bank_regs #(.NLINES(NLINES), .HAS_DUAL(HAS_DUAL)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cfg_q     (cfg_q),
        .clr_pulse (clr_pulse)
    );

    gpio_bank_sense u_sense (
        .clk      (clk),
        .rst      (rst),
        .pad      (pad_ext),
        .mode     (cfg_q.mode),
        .pol      (cfg_q.pol),
        .edg      (cfg_q.edg),
        .dual     (cfg_q.dual),
        .clr      (clr_pulse),
        .status_q (status_q)
    );

    gpio_bank_rdmux u_rdmux (
        .bus_addr (bus_addr),
        .cfg      (cfg_q),
        .pad      (pad_ext),
        .status   (status_q),
        .rdata    (bus_rdata)
    );

    assign oe_full = ~cfg_q.mode & cfg_q.dir;
    assign pad_oe  = oe_full[NLINES-1:0];
    assign pad_out = cfg_q.dout[NLINES-1:0];
    assign irq     = |(status_q & cfg_q.mask);

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [NLINES-1:0] pad_oe,
    input logic [NLINES-1:0] pad_out,
    input logic              irq,
    input line_vec_t         mask_q,
    input line_vec_t         mode_q,
    input line_vec_t         status_q
);

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && irq == 1'b0));

    // R2: pad outputs only move after a bus write
    a_r2_pads_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> ($stable(pad_oe) && $stable(pad_out)));

    // R4: the clearing mask offset never sets a bit
    a_r4_mask_only_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_MASK) |=> ((mask_q & ~$past(mask_q)) == '0));

    // R5: an interrupt needs an enabled line
    a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != '0));

    // R9: general I/O lines carry no status
    a_r9_io_no_status: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(mode_q)) == '0));

    // R10: write-only and unused offsets read zero
    a_r10_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_CLR || bus_addr == OFF_MSET || bus_addr == OFF_FILT ||
         bus_addr == 7'h30 || bus_addr == 7'h7C) |-> (bus_rdata == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.NLINES(NLINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq),
    .mask_q    (cfg_q.mask),
    .mode_q    (cfg_q.mode),
    .status_q  (status_q)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    import gpio_bank_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       pad_in = '0;
    logic [31:0]       pad_oe;
    logic [31:0]       pad_out;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;

    // shadow model built from the requirements
    logic [31:0] m_mode = '0, m_dir = '0, m_dout = '0, m_mask = '0;
    logic [31:0] m_pol = '0, m_edg = '0, m_dual = '0, m_latch = '0, m_prev = '0;

    always #10 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            OFF_MODE: begin m_mode = d; m_latch = m_latch & d; end
            OFF_DIR:  m_dir  = d;
            OFF_DOUT: m_dout = d;
            OFF_CLR:  m_latch = m_latch & ~d;
            OFF_MASK: m_mask = m_mask & d;
            OFF_MSET: m_mask = m_mask | d;
            OFF_POL:  m_pol  = d;
            OFF_EDGE: m_edg  = d;
            OFF_DUAL: m_dual = d;
            default:  ;
        endcase
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_status();
        return m_mode & ((~m_edg & (pad_in ^ m_pol)) | (m_edg & m_latch));
    endfunction

    // drive a new pad vector, optionally with a clear write in the same cycle
    task automatic step(input logic [31:0] p, input logic [31:0] clr);
        logic [31:0] rise, fall, hit;
        @(negedge clk);
        pad_in = p;
        if (clr != '0) begin
            bus_addr = OFF_CLR; bus_we = 1'b1; bus_wdata = clr;
        end
        rise = p & ~m_prev;
        fall = ~p & m_prev;
        hit  = m_mode & m_edg & ((m_dual & (rise | fall)) | (~m_dual & ((m_pol & fall) | (~m_pol & rise))));
        m_latch = (m_latch & ~clr) | hit;
        m_prev  = p;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        m_prev = pad_in;
    endtask

    task automatic check_status(input string req);
        logic [31:0] s, e;
        e = exp_status();
        rd(OFF_STAT, s);
        check(req, s, e);
        check({req, "/R5 irq"}, {31'd0, irq}, {31'd0, |(e & m_mask)});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        begin
            logic [ADDR_W-1:0] offs [9] = '{OFF_MODE, OFF_DIR, OFF_DOUT, OFF_STAT,
                                           OFF_MASK, OFF_POL, OFF_EDGE, OFF_DUAL, OFF_FILT};
            foreach (offs[k]) begin
                rd(offs[k], v);
                check("R1 register reset", v, 32'h0);
            end
        end
        check("R1 pad_oe reset", pad_oe, 32'h0);
        check("R1 irq reset", {31'd0, irq}, 32'h0);

        // R2 / R3: direction, mode and readback under several patterns
        seed = 32'h1234_5678;
        for (int k = 0; k < 6; k++) begin
            logic [31:0] md, dr, dd, pd;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            md = (k == 0) ? 32'h0 : seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            dr = (k == 1) ? 32'hFFFF_FFFF : seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            dd = seed;
            pd = ~seed ^ 32'h5A5A_A5A5;
            wr(OFF_MODE, md);
            wr(OFF_DIR, dr);
            wr(OFF_DOUT, dd);
            pad_in = pd;
            check("R2 pad_oe", pad_oe, ~md & dr);
            check("R2 pad_out", pad_out, dd);
            rd(OFF_DIN, v);
            check("R3 input readback", v, ((~md & dr) & dd) | (~(~md & dr) & pd));
            idle();
        end
        wr(OFF_MODE, 32'h0);
        wr(OFF_DIR, 32'h0);
        pad_in = '0;
        idle();

        // R4: mask set and clear offsets
        wr(OFF_MSET, 32'hFFFF_0000);
        wr(OFF_MSET, 32'h0000_00FF);
        rd(OFF_MASK, v);
        check("R4 mask set", v, 32'hFFFF_00FF);
        wr(OFF_MASK, 32'h0F0F_0F0F);
        rd(OFF_MASK, v);
        check("R4 mask clear zeros only", v, 32'h0F0F_000F);
        wr(OFF_MASK, 32'hFFFF_FFFF);
        rd(OFF_MASK, v);
        check("R4 mask write ones keeps", v, 32'h0F0F_000F);
        wr(OFF_MSET, 32'hFFFF_FFFF);

        // R6 R7 R8 R9 R11: every line through every trigger setting
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < 8; c++) begin
                logic [31:0] bit_i;
                logic [31:0] seq [6];
                bit_i = 32'd1 << i;
                wr(OFF_MODE, 32'h0);
                pad_in = '0;
                idle();
                wr(OFF_POL,  c[0] ? bit_i : 32'h0);
                wr(OFF_EDGE, c[1] ? bit_i : 32'h0);
                wr(OFF_DUAL, c[2] ? bit_i : 32'h0);
                wr(OFF_MODE, bit_i);
                wr(OFF_CLR, 32'hFFFF_FFFF);
                idle();
                check_status("R9 after config");
                seq = '{bit_i, bit_i, 32'h0, 32'h0, bit_i, 32'h0};
                for (int s = 0; s < 6; s++) begin
                    logic [31:0] p;
                    p = seq[s] | (~bit_i & (seq[s][i] ? 32'h0 : 32'hFFFF_FFFF));
                    step(p, (s == 4) ? bit_i : 32'h0);
                    if (s == 4) check_status("R11 edge beats clear");
                    else if (c[1] && c[2]) check_status("R7 dual edge");
                    else if (c[1]) check_status("R6 edge latch");
                    else check_status("R8 level follows");
                    if (s == 1) begin
                        wr(OFF_CLR, 32'h0);
                        check_status("R6 clear zero no effect");
                        wr(OFF_CLR, bit_i);
                        check_status(c[1] ? "R6 clear one" : "R8 clear ignored");
                    end
                end
            end
        end

        // R5: status visible while masked, irq gated
        wr(OFF_MODE, 32'h0000_0001);
        wr(OFF_EDGE, 32'h0000_0000);
        wr(OFF_POL,  32'h0000_0000);
        step(32'h0000_0001, 32'h0);
        wr(OFF_MASK, 32'hFFFF_FFFE);
        rd(OFF_STAT, v);
        check("R5 status while masked", v, 32'h0000_0001);
        check("R5 irq masked", {31'd0, irq}, 32'h0);
        wr(OFF_MSET, 32'h0000_0001);
        check("R5 irq enabled", {31'd0, irq}, 32'h1);

        // R10: dead offsets read zero, writes to them change nothing
        wr(OFF_DIR, 32'hC3C3_3C3C);
        wr(OFF_FILT, 32'hFFFF_FFFF);
        wr(7'h30, 32'hFFFF_FFFF);
        wr(7'h7C, 32'hFFFF_FFFF);
        rd(OFF_FILT, v); check("R10 filter reads zero", v, 32'h0);
        rd(OFF_CLR, v);  check("R10 clear reads zero", v, 32'h0);
        rd(OFF_MSET, v); check("R10 set-enable reads zero", v, 32'h0);
        rd(7'h30, v);    check("R10 unmapped reads zero", v, 32'h0);
        rd(OFF_DIR, v);  check("R10 direction untouched", v, 32'hC3C3_3C3C);
        rd(OFF_MODE, v); check("R10 mode untouched", v, 32'h0000_0001);
        rd(OFF_MASK, v); check("R10 mask untouched", v, 32'hFFFF_FFFF);
        rd(OFF_POL, v);  check("R10 polarity untouched", v, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule